// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

This block joins one processor-side data port (A) to two memory-side ports: port One, which serves the even bank, and port Two, which serves the odd bank. Traffic from A toward each memory port goes through its own hold stage. Traffic from each memory port toward A goes through its own hold stage and then through a two-way selector that picks which bank reaches A. Each of the four hold stages has its own open control. While the control is high, the stage passes its input straight through. When it is low, the stage holds a captured value.

The stages are built from flops and a bypass multiplexer in a single clock domain, so the block stays free of real latches. An open stage passes its input to its output in the same cycle. A closed stage outputs the input value seen at the last rising clock edge at which it was open. Each port has an active-low output enable. At the block edge, every bidirectional port is split into an input bus, an output bus and an active-high drive flag; the pad ring or bench resolves the tri-state. A typical use is to write one bank from A while the other bank is read, or to capture one word from each bank and hand them to A in turn by flipping the selector.

Top module: `tri_port_exchanger`

## Requirements
- R1: After reset is released, with every stage closed and every enable high, aOut, oneOut and twoOut read 0 and all three drive flags read 0.
- R2: While openAtoOne is 1, oneOut equals aIn in the same cycle. While openAtoTwo is 1, twoOut equals aIn in the same cycle.
- R3: Once openAtoOne is 0, oneOut holds the aIn value sampled at the last rising clock edge at which openAtoOne was 1. It does not change as aIn changes until openAtoOne returns to 1.
- R4: The A-to-Two stage holds in the same way on openAtoTwo. It is independent of the A-to-One stage: opening or closing one leaves the other's output unchanged.
- R5: The One-to-A stage (control openOneToA, input oneIn) and the Two-to-A stage (control openTwoToA, input twoIn) pass their inputs while open. When closed, each holds its last sampled value.
- R6: With selOne = 1, aOut shows the One-to-A stage. With selOne = 0, aOut shows the Two-to-A stage.
- R7: Toggling selOne while both toward-A stages are closed switches aOut between the two held words and alters neither of them.
- R8: aOe = NOT oeAN, oneOe = NOT oeOneN and twoOe = NOT oeTwoN, each independent of the others. Changing an enable does not alter any held value.
- R9: One memory port can drive a held word while the other acts as an input whose data reaches A through its open stage.
- R10: Driving rstN low at any time, between clock edges included, clears all four held values at once. Open stages stay transparent while reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold flops |
| rstN | input | 1 | Asynchronous active-low reset |
| aIn | input | WIDTH | Data arriving on port A |
| aOut | output | WIDTH | Data for port A, taken from the selected toward-A stage |
| aOe | output | 1 | High when port A should drive |
| oneIn | input | WIDTH | Data arriving on port One |
| oneOut | output | WIDTH | Data for port One from the A-to-One stage |
| oneOe | output | 1 | High when port One should drive |
| twoIn | input | WIDTH | Data arriving on port Two |
| twoOut | output | WIDTH | Data for port Two from the A-to-Two stage |
| twoOe | output | 1 | High when port Two should drive |
| openAtoOne | input | 1 | Open control of the A-to-One stage |
| openAtoTwo | input | 1 | Open control of the A-to-Two stage |
| openOneToA | input | 1 | Open control of the One-to-A stage |
| openTwoToA | input | 1 | Open control of the Two-to-A stage |
| selOne | input | 1 | 1 selects the One-to-A stage for A, 0 selects Two-to-A |
| oeAN | input | 1 | Active-low output enable for port A |
| oeOneN | input | 1 | Active-low output enable for port One |
| oeTwoN | input | 1 | Active-low output enable for port Two |

## Verification
A wrong held value cannot hide: it appears on its port output in the first cycle the stage is closed. For a toward-A stage, it appears as soon as the selector points at it. A stage that captures on the wrong edge, or that keeps following its input after closing, shows a mismatch on the first input change after the close. The checks therefore close every stage and then change its input at once. Selector and enable faults show in the same cycle as the control change. The bench also flips the selector back and forth over two different held words, so a swapped or disturbed word is caught within one cycle.

// File: rtl/exch_pkg.sv
package exch_pkg;

  localparam int DATA_W    = 12;
  localparam int N_STAGES  = 4;

  // stage indices inside the datapath
  localparam int ST_A_ONE = 0;
  localparam int ST_A_TWO = 1;
  localparam int ST_ONE_A = 2;
  localparam int ST_TWO_A = 3;

  typedef struct packed {
    logic [N_STAGES-1:0] openStage;
    logic                pickOne;
    logic                driveA;
    logic                driveOne;
    logic                driveTwo;
  } exch_strobe_t;

endpackage

// File: rtl/exch_hold_stage.sv
module exch_hold_stage #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             open,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] heldQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldQ <= '0;
    end else if (open) begin
      heldQ <= dIn;
    end
  end

  // transparent while open, otherwise the captured word
  assign qOut = open ? dIn : heldQ;

endmodule

// File: rtl/exch_ctrl.sv
module exch_ctrl
  import exch_pkg::*;
(
  input  logic         openAtoOne,
  input  logic         openAtoTwo,
  input  logic         openOneToA,
  input  logic         openTwoToA,
  input  logic         selOne,
  input  logic         oeAN,
  input  logic         oeOneN,
  input  logic         oeTwoN,
  output exch_strobe_t strobe
);

  always_comb begin
    strobe                     = '0;
    strobe.openStage[ST_A_ONE] = openAtoOne;
    strobe.openStage[ST_A_TWO] = openAtoTwo;
    strobe.openStage[ST_ONE_A] = openOneToA;
    strobe.openStage[ST_TWO_A] = openTwoToA;
    strobe.pickOne             = selOne;
    strobe.driveA              = ~oeAN;
    strobe.driveOne            = ~oeOneN;
    strobe.driveTwo            = ~oeTwoN;
  end

endmodule

// File: rtl/exch_datapath.sv
module exch_datapath
  import exch_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  exch_strobe_t     strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] oneIn,
  input  logic [WIDTH-1:0] twoIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] oneOut,
  output logic [WIDTH-1:0] twoOut
);

  logic [WIDTH-1:0] stageIn  [N_STAGES];
  logic [WIDTH-1:0] stageOut [N_STAGES];

  assign stageIn[ST_A_ONE] = aIn;
  assign stageIn[ST_A_TWO] = aIn;
  assign stageIn[ST_ONE_A] = oneIn;
  assign stageIn[ST_TWO_A] = twoIn;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    exch_hold_stage #(.WIDTH(WIDTH)) stage_i (
      .clk  (clk),
      .rstN (rstN),
      .open (strobe.openStage[g]),
      .dIn  (stageIn[g]),
      .qOut (stageOut[g])
    );
  end

  assign oneOut = stageOut[ST_A_ONE];
  assign twoOut = stageOut[ST_A_TWO];
  assign aOut   = strobe.pickOne ? stageOut[ST_ONE_A] : stageOut[ST_TWO_A];

endmodule

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger
  import exch_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] oneIn,
  output logic [WIDTH-1:0] oneOut,
  output logic             oneOe,
  input  logic [WIDTH-1:0] twoIn,
  output logic [WIDTH-1:0] twoOut,
  output logic             twoOe,
  input  logic             openAtoOne,
  input  logic             openAtoTwo,
  input  logic             openOneToA,
  input  logic             openTwoToA,
  input  logic             selOne,
  input  logic             oeAN,
  input  logic             oeOneN,
  input  logic             oeTwoN
);

  exch_strobe_t strobe;

  exch_ctrl ctrl_i (
    .openAtoOne (openAtoOne),
    .openAtoTwo (openAtoTwo),
    .openOneToA (openOneToA),
    .openTwoToA (openTwoToA),
    .selOne     (selOne),
    .oeAN       (oeAN),
    .oeOneN     (oeOneN),
    .oeTwoN     (oeTwoN),
    .strobe     (strobe)
  );

  exch_datapath #(.WIDTH(WIDTH)) path_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .aIn    (aIn),
    .oneIn  (oneIn),
    .twoIn  (twoIn),
    .aOut   (aOut),
    .oneOut (oneOut),
    .twoOut (twoOut)
  );

  assign aOe   = strobe.driveA;
  assign oneOe = strobe.driveOne;
  assign twoOe = strobe.driveTwo;

endmodule

// File: rtl/exch_checker.sv
module exch_checker #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic             aOe,
  input logic [WIDTH-1:0] oneIn,
  input logic [WIDTH-1:0] oneOut,
  input logic             oneOe,
  input logic [WIDTH-1:0] twoIn,
  input logic [WIDTH-1:0] twoOut,
  input logic             twoOe,
  input logic             openAtoOne,
  input logic             openAtoTwo,
  input logic             openOneToA,
  input logic             openTwoToA,
  input logic             selOne,
  input logic             oeAN,
  input logic             oeOneN,
  input logic             oeTwoN
);

  a_r2_pass_one: assert property (@(posedge clk) disable iff (!rstN)
    openAtoOne |-> (oneOut == aIn));

  a_r2_pass_two: assert property (@(posedge clk) disable iff (!rstN)
    openAtoTwo |-> (twoOut == aIn));

  a_r3_hold_one: assert property (@(posedge clk) disable iff (!rstN)
    (!openAtoOne && $past(!openAtoOne)) |-> $stable(oneOut));

  a_r4_hold_two: assert property (@(posedge clk) disable iff (!rstN)
    (!openAtoTwo && $past(!openAtoTwo)) |-> $stable(twoOut));

  a_r6_pick_one: assert property (@(posedge clk) disable iff (!rstN)
    (selOne && openOneToA) |-> (aOut == oneIn));

  a_r6_pick_two: assert property (@(posedge clk) disable iff (!rstN)
    (!selOne && openTwoToA) |-> (aOut == twoIn));

  a_r5_hold_toward_a: assert property (@(posedge clk) disable iff (!rstN)
    (selOne && $past(selOne) && !openOneToA && $past(!openOneToA)) |-> $stable(aOut));

  a_r8_enables: assert property (@(posedge clk) disable iff (!rstN)
    (aOe == !oeAN) && (oneOe == !oeOneN) && (twoOe == !oeTwoN));

endmodule

bind tri_port_exchanger exch_checker #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/tri_port_exchanger_tb_top.sv
module tri_port_exchanger_tb_top;

  localparam int W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, oneIn = '0, twoIn = '0;
  logic [W-1:0] aOut, oneOut, twoOut;
  logic aOe, oneOe, twoOe;
  logic openAtoOne = 1'b0, openAtoTwo = 1'b0, openOneToA = 1'b0, openTwoToA = 1'b0;
  logic selOne = 1'b0, oeAN = 1'b1, oeOneN = 1'b1, oeTwoN = 1'b1;

  always #10 clk = ~clk;

  tri_port_exchanger #(.WIDTH(W)) dut_i (.*);

  typedef struct {
    string        req;
    logic [W-1:0] expA, expOne, expTwo;
    logic [2:0]   expOe;
  } exp_item_t;

  exp_item_t sbQ[$];
  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  // reference hold values, from the requirements
  logic [W-1:0] mA1 = '0, mA2 = '0, m1A = '0, m2A = '0;

  task automatic step(input logic rst, input logic [W-1:0] a, input logic [W-1:0] one,
                      input logic [W-1:0] two, input logic [3:0] opens, input logic sel,
                      input logic [2:0] oeN, input string req);
    exp_item_t it;
    logic [W-1:0] r1A, r2A;
    @(posedge clk);
    if (!rstN) begin
      mA1 = '0; mA2 = '0; m1A = '0; m2A = '0;
    end else begin
      if (openAtoOne) mA1 = aIn;
      if (openAtoTwo) mA2 = aIn;
      if (openOneToA) m1A = oneIn;
      if (openTwoToA) m2A = twoIn;
    end
    #2;
    rstN = rst; aIn = a; oneIn = one; twoIn = two;
    {openTwoToA, openOneToA, openAtoTwo, openAtoOne} = opens;
    selOne = sel; {oeAN, oeOneN, oeTwoN} = oeN;
    if (!rst) begin
      mA1 = '0; mA2 = '0; m1A = '0; m2A = '0;
    end
    r1A = opens[2] ? one : m1A;
    r2A = opens[3] ? two : m2A;
    it.req    = req;
    it.expOne = opens[0] ? a : mA1;
    it.expTwo = opens[1] ? a : mA2;
    it.expA   = sel ? r1A : r2A;
    it.expOe  = ~oeN;
    sbQ.push_back(it);
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        exp_item_t e;
        e = sbQ.pop_front();
        testsRun++;
        if (aOut !== e.expA || oneOut !== e.expOne || twoOut !== e.expTwo ||
            {aOe, oneOe, twoOe} !== e.expOe) begin
          testsFailed++;
          $display("FAIL %s: got a=%h one=%h two=%h oe=%b, expected a=%h one=%h two=%h oe=%b",
                   e.req, aOut, oneOut, twoOut, {aOe, oneOe, twoOe},
                   e.expA, e.expOne, e.expTwo, e.expOe);
        end
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // opens = {twoToA, oneToA, aToTwo, aToOne}; oeN = {A, One, Two}
    repeat (2) @(posedge clk);
    step(1, 12'h000, 12'h000, 12'h000, 4'b0000, 0, 3'b111, "R1");
    step(1, 12'h5A5, 12'h3C3, 12'h0F0, 4'b0000, 1, 3'b111, "R1");
    // R2: A to One transparent
    step(1, 12'h123, 12'h000, 12'h000, 4'b0001, 0, 3'b101, "R2");
    step(1, 12'hABC, 12'h000, 12'h000, 4'b0001, 0, 3'b101, "R2");
    // R3: close and change aIn at once, then keep changing
    step(1, 12'hFFF, 12'h000, 12'h000, 4'b0000, 0, 3'b101, "R3");
    step(1, 12'h001, 12'h000, 12'h000, 4'b0000, 0, 3'b101, "R3");
    // R4: A to Two open, One still held
    step(1, 12'h777, 12'h000, 12'h000, 4'b0010, 0, 3'b110, "R4");
    step(1, 12'h456, 12'h000, 12'h000, 4'b0010, 0, 3'b110, "R4");
    step(1, 12'h999, 12'h000, 12'h000, 4'b0000, 0, 3'b110, "R4");
    step(1, 12'h888, 12'h000, 12'h000, 4'b0001, 0, 3'b110, "R4");
    step(1, 12'h222, 12'h000, 12'h000, 4'b0000, 0, 3'b100, "R4");
    // R5/R6: toward-A stages
    step(1, 12'h000, 12'h111, 12'h2E2, 4'b1100, 1, 3'b011, "R6");
    step(1, 12'h000, 12'hA1A, 12'hB2B, 4'b1100, 0, 3'b011, "R6");
    step(1, 12'h000, 12'h0D0, 12'h0E0, 4'b0000, 1, 3'b011, "R5");
    step(1, 12'h000, 12'h333, 12'h444, 4'b0000, 0, 3'b011, "R5");
    // R7: toggle select over two held words
    step(1, 12'h000, 12'h555, 12'h666, 4'b0000, 1, 3'b011, "R7");
    step(1, 12'h000, 12'h777, 12'h888, 4'b0000, 0, 3'b011, "R7");
    step(1, 12'h000, 12'h999, 12'hAAA, 4'b0000, 1, 3'b011, "R7");
    // R8: enables independent and harmless
    step(1, 12'h000, 12'h000, 12'h000, 4'b0000, 1, 3'b010, "R8");
    step(1, 12'h000, 12'h000, 12'h000, 4'b0000, 0, 3'b101, "R8");
    step(1, 12'h000, 12'h000, 12'h000, 4'b0000, 1, 3'b000, "R8");
    // R9: One drives held word, Two feeds A
    step(1, 12'hC0C, 12'h000, 12'h3A3, 4'b1001, 0, 3'b001, "R9");
    step(1, 12'h000, 12'h000, 12'h4B4, 4'b1000, 0, 3'b001, "R9");
    step(1, 12'h000, 12'h000, 12'h5C5, 4'b1000, 0, 3'b001, "R9");
    // R10: reset between edges clears held words
    step(1, 12'h000, 12'h000, 12'h000, 4'b0000, 1, 3'b000, "R10");
    step(0, 12'h000, 12'h000, 12'h000, 4'b0000, 0, 3'b000, "R10");
    step(0, 12'h6D6, 12'h000, 12'h000, 4'b0001, 1, 3'b000, "R10");
    step(1, 12'h000, 12'h000, 12'h000, 4'b0000, 1, 3'b000, "R10");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule